// File: doc/BRIEF.md
# Page-Based Packet Buffer Allocator

This block manages a shared on-chip packet RAM as a pool of fixed 256-byte pages. Transmit and receive both draw from the same pool on demand, with no split between them. A packet is known everywhere by a small packet number. The block hands out numbers and pages when an allocation is asked for, takes them back on release, and moves the numbers through three queues: transmit, transmit completion and receive. A host command port issues allocate, release, enqueue and pop commands. A receive-side port asks for buffer space for incoming frames. A transmit-side port takes queued packets and reports the ones it has finished.

An allocation of N bytes needs one page per started 256 bytes, and at least one page. The free-page count is reserved at once. The pages are then claimed one per cycle, lowest free page first, while a busy flag is raised. A combinational translator turns a packet number and byte offset into a physical RAM address. It picks the k-th lowest page the packet owns, where k is the offset divided by 256, and appends the low eight offset bits.

Top module: `pga_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `free_pages` equals NUM_PAGES, `busy`, `alloc_done`, `alloc_fail` and `rx_overrun` are low, and all three queues report empty.
- R2: Host command code 1 (allocate `cmd_bytes`) needs ceil(bytes/256) pages, and at least 1 page. On success `free_pages` falls by that count on the accepting edge. `busy` is then high for exactly that many cycles. `alloc_done` pulses for one cycle on the edge where `busy` falls, and `alloc_pkt` holds the lowest packet number not in use.
- R3: An allocation whose page count exceeds `free_pages`, or that finds no unused packet number, pulses `alloc_fail` one cycle after it is issued. In that case `busy` stays low and neither pages nor numbers are consumed.
- R4: Host commands of every code are ignored while `busy` is high.
- R5: Host command code 2 releases every page of packet `cmd_pkt` and frees its number. `free_pages` rises by that page count on the accepting edge. Releasing a number not in use has no effect.
- R6: Host command code 6 appends `cmd_pkt` to the transmit queue. `tx_head` and `tx_empty` show the oldest entry, and a `tx_pop` pulse removes it.
- R7: A `tx_done_valid` pulse with `auto_release` high frees the pages of `tx_done_pkt` and leaves the completion queue untouched. With `auto_release` low it appends `tx_done_pkt` to the completion queue and keeps its pages.
- R8: A `rx_alloc_req` pulse allocates like R2 but raises neither `alloc_done` nor `alloc_fail`. The packet number is appended to the receive queue on the edge where the allocation completes. If the request cannot be met, because pages or numbers are short or because `busy` is high, `rx_overrun` pulses on the next cycle.
- R9: When a host allocate and a receive allocation arrive in the same idle cycle, the receive request is served and the host request reports `alloc_fail`.
- R10: `xl_hit` is high and `xl_addr` = {page, `xl_offset`[7:0]} when packet `xl_pkt` owns at least k+1 pages, with k = `xl_offset`>>8. The page is the k-th lowest-indexed page the packet owns. Otherwise `xl_hit` is low.
- R11: Host command code 3 pops the receive queue and code 4 pops the completion queue. A pop of an empty queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_code | input | 3 | Host command code |
| cmd_bytes | input | BYTE_W | Byte count for allocate |
| cmd_pkt | input | PKT_W | Packet number for release or enqueue |
| busy | output | 1 | Allocation in progress |
| alloc_done | output | 1 | Host allocation finished (pulse) |
| alloc_fail | output | 1 | Host allocation refused (pulse) |
| alloc_pkt | output | PKT_W | Number given by the latest allocation |
| free_pages | output | CNT_W | Unreserved page count |
| auto_release | input | 1 | Free pages of finished transmits at once |
| rx_alloc_req | input | 1 | Receive-side allocation request |
| rx_alloc_bytes | input | BYTE_W | Receive frame byte count |
| rx_overrun | output | 1 | Receive allocation refused (pulse) |
| rx_head | output | PKT_W | Oldest receive queue entry |
| rx_empty | output | 1 | Receive queue empty |
| tx_pop | input | 1 | Transmit side takes the queue head |
| tx_head | output | PKT_W | Oldest transmit queue entry |
| tx_empty | output | 1 | Transmit queue empty |
| tx_done_valid | input | 1 | Transmit finished strobe |
| tx_done_pkt | input | PKT_W | Number of the finished packet |
| done_head | output | PKT_W | Oldest completion queue entry |
| done_empty | output | 1 | Completion queue empty |
| xl_pkt | input | PKT_W | Packet number to translate |
| xl_offset | input | BYTE_W | Byte offset within the packet |
| xl_addr | output | ADDR_W | Physical RAM byte address |
| xl_hit | output | 1 | Translation valid |

## Verification
The hardest situations to reach are those where two sources act in the same cycle. One is a host allocate that coincides with a receive allocation. The other is a command or a receive request that lands inside the busy window of a running allocation. The bench first fills and drains the pool through a vector table to known page placements. It then drives the contending requests on the same falling clock edge, and places commands one and two cycles into a four-page allocation. Queue contents, the free count and the translated addresses show afterwards whether anything slipped through.

// File: rtl/pga_pkg.sv
package pga_pkg;

    localparam int PAGE_SHIFT = 8;

    typedef enum logic [2:0] {
        CMD_NOP      = 3'd0,
        CMD_ALLOC    = 3'd1,
        CMD_RELEASE  = 3'd2,
        CMD_POP_RX   = 3'd3,
        CMD_POP_DONE = 3'd4,
        CMD_RSV5     = 3'd5,
        CMD_ENQ_TX   = 3'd6,
        CMD_RSV7     = 3'd7
    } host_cmd_e;

    // One allocation request after arbitration between host and receive side
    typedef struct packed {
        logic        go;
        logic        from_rx;
        logic [15:0] pages;
    } alloc_req_t;

    // Started 256-byte pages, never less than one
    function automatic logic [15:0] pages_for_bytes(input logic [15:0] nbytes);
        logic [15:0] p;
        p = {8'd0, nbytes[15:PAGE_SHIFT]} + {15'd0, |nbytes[PAGE_SHIFT-1:0]};
        if (p == 16'd0) p = 16'd1;
        return p;
    endfunction

endpackage

// File: rtl/pga_num_fifo.sv
module pga_num_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign do_push = push && (cnt_q != CW'(DEPTH));
    assign do_pop  = pop && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= push_data;
    end

    assign head  = mem_q[rd_q];
    assign empty = (cnt_q == '0);
endmodule

// File: rtl/pga_page_table.sv
module pga_page_table #(
    parameter int NUM_PAGES = 24,
    parameter int PKT_W     = 4,
    parameter int RK_W      = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rel_a_en,
    input  logic [PKT_W-1:0]              rel_a_pkt,
    input  logic                          rel_b_en,
    input  logic [PKT_W-1:0]              rel_b_pkt,
    input  logic                          claim_en,
    input  logic [PKT_W-1:0]              claim_pkt,
    output logic [$clog2(NUM_PAGES+1)-1:0] freed_cnt,
    input  logic [PKT_W-1:0]              xl_pkt,
    input  logic [RK_W-1:0]               xl_rank,
    output logic                          xl_hit,
    output logic [$clog2(NUM_PAGES)-1:0]  xl_page
);
    localparam int PG_W = $clog2(NUM_PAGES);
    localparam int CW   = $clog2(NUM_PAGES + 1);

    logic [NUM_PAGES-1:0] used_q;
    logic [NUM_PAGES-1:0] rel_hit;
    logic [PKT_W-1:0]     own_q [NUM_PAGES];
    logic [PG_W-1:0]      claim_idx;

    // Lowest free page
    always_comb begin
        claim_idx = '0;
        for (int p = NUM_PAGES - 1; p >= 0; p--) begin
            if (!used_q[p]) claim_idx = PG_W'(p);
        end
    end

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
        logic             used_r;
        logic [PKT_W-1:0] own_r;

        assign rel_hit[g] = used_r &&
                            ((rel_a_en && own_r == rel_a_pkt) ||
                             (rel_b_en && own_r == rel_b_pkt));

        always_ff @(posedge clk) begin
            if (rst) begin
                used_r <= 1'b0;
                own_r  <= '0;
            end else if (rel_hit[g]) begin
                used_r <= 1'b0;
            end else if (claim_en && !used_r && claim_idx == PG_W'(g)) begin
                used_r <= 1'b1;
                own_r  <= claim_pkt;
            end
        end

        assign used_q[g] = used_r;
        assign own_q[g]  = own_r;
    end

    assign freed_cnt = CW'($countones(rel_hit));

    // k-th lowest page owned by the packet
    always_comb begin
        int rank;
        rank    = 0;
        xl_hit  = 1'b0;
        xl_page = '0;
        for (int p = 0; p < NUM_PAGES; p++) begin
            if (used_q[p] && own_q[p] == xl_pkt) begin
                if (!xl_hit && rank == int'(xl_rank)) begin
                    xl_hit  = 1'b1;
                    xl_page = PG_W'(p);
                end
                rank = rank + 1;
            end
        end
    end
endmodule

// File: rtl/pga_top.sv
module pga_top
    import pga_pkg::*;
#(
    parameter int NUM_PAGES = 24,
    parameter int NUM_PKTS  = 16,
    parameter int BYTE_W    = 13,
    localparam int PKT_W    = $clog2(NUM_PKTS),
    localparam int PG_W     = $clog2(NUM_PAGES),
    localparam int CNT_W    = $clog2(NUM_PAGES + 1),
    localparam int ADDR_W   = PG_W + PAGE_SHIFT,
    localparam int RK_W     = BYTE_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [BYTE_W-1:0] cmd_bytes,
    input  logic [PKT_W-1:0]  cmd_pkt,
    output logic              busy,
    output logic              alloc_done,
    output logic              alloc_fail,
    output logic [PKT_W-1:0]  alloc_pkt,
    output logic [CNT_W-1:0]  free_pages,
    input  logic              auto_release,
    input  logic              rx_alloc_req,
    input  logic [BYTE_W-1:0] rx_alloc_bytes,
    output logic              rx_overrun,
    output logic [PKT_W-1:0]  rx_head,
    output logic              rx_empty,
    input  logic              tx_pop,
    output logic [PKT_W-1:0]  tx_head,
    output logic              tx_empty,
    input  logic              tx_done_valid,
    input  logic [PKT_W-1:0]  tx_done_pkt,
    output logic [PKT_W-1:0]  done_head,
    output logic              done_empty,
    input  logic [PKT_W-1:0]  xl_pkt,
    input  logic [BYTE_W-1:0] xl_offset,
    output logic [ADDR_W-1:0] xl_addr,
    output logic              xl_hit
);
    host_cmd_e           cmd_e;
    logic                host_go;
    logic                busy_q, done_q, fail_q, ovr_q, cur_rx_q;
    logic [CNT_W-1:0]    free_q, remain_q, freed_cnt;
    logic [PKT_W-1:0]    cur_pkt_q, spare_num;
    logic                spare_ok;
    logic [NUM_PKTS-1:0] pkt_used_q, rel_mask, grant_mask;
    alloc_req_t          areq;
    logic                fits, alloc_ok, host_fail, rx_fail;
    logic                rel_a, rel_b, rx_push, last_claim;
    logic [PG_W-1:0]     xl_page;

    assign cmd_e   = host_cmd_e'(cmd_code);
    assign host_go = cmd_valid && !busy_q;

    function automatic logic live(input logic [NUM_PKTS-1:0] used, input logic [PKT_W-1:0] p);
        return (int'(p) < NUM_PKTS) && used[p];
    endfunction

    // Lowest unused packet number
    always_comb begin
        spare_ok  = 1'b0;
        spare_num = '0;
        for (int n = NUM_PKTS - 1; n >= 0; n--) begin
            if (!pkt_used_q[n]) begin
                spare_ok  = 1'b1;
                spare_num = PKT_W'(n);
            end
        end
    end

    // Receive side wins over the host when both allocate
    always_comb begin
        areq = '0;
        if (!busy_q && rx_alloc_req) begin
            areq.go      = 1'b1;
            areq.from_rx = 1'b1;
            areq.pages   = pages_for_bytes(16'(rx_alloc_bytes));
        end else if (host_go && cmd_e == CMD_ALLOC) begin
            areq.go    = 1'b1;
            areq.pages = pages_for_bytes(16'(cmd_bytes));
        end
    end

    assign fits      = spare_ok && (areq.pages <= 16'(free_q));
    assign alloc_ok  = areq.go && fits;
    assign host_fail = host_go && cmd_e == CMD_ALLOC && (rx_alloc_req || !fits);
    assign rx_fail   = rx_alloc_req && (busy_q || !fits);

    assign rel_a = host_go && cmd_e == CMD_RELEASE && live(pkt_used_q, cmd_pkt);
    assign rel_b = tx_done_valid && auto_release && live(pkt_used_q, tx_done_pkt);

    always_comb begin
        rel_mask = '0;
        for (int n = 0; n < NUM_PKTS; n++) begin
            if ((rel_a && cmd_pkt == PKT_W'(n)) || (rel_b && tx_done_pkt == PKT_W'(n)))
                rel_mask[n] = 1'b1;
        end
    end

    assign grant_mask = alloc_ok ? (NUM_PKTS'(1) << spare_num) : '0;
    assign last_claim = busy_q && remain_q == CNT_W'(1);
    assign rx_push    = last_claim && cur_rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
            fail_q     <= 1'b0;
            ovr_q      <= 1'b0;
            cur_rx_q   <= 1'b0;
            remain_q   <= '0;
            cur_pkt_q  <= '0;
            free_q     <= CNT_W'(NUM_PAGES);
            pkt_used_q <= '0;
        end else begin
            done_q     <= 1'b0;
            fail_q     <= host_fail;
            ovr_q      <= rx_fail;
            free_q     <= free_q + freed_cnt - (alloc_ok ? CNT_W'(areq.pages) : '0);
            pkt_used_q <= (pkt_used_q & ~rel_mask) | grant_mask;
            if (alloc_ok) begin
                busy_q    <= 1'b1;
                remain_q  <= CNT_W'(areq.pages);
                cur_pkt_q <= spare_num;
                cur_rx_q  <= areq.from_rx;
            end else if (busy_q) begin
                remain_q <= remain_q - 1'b1;
                if (last_claim) begin
                    busy_q <= 1'b0;
                    done_q <= !cur_rx_q;
                end
            end
        end
    end

    pga_page_table #(
        .NUM_PAGES(NUM_PAGES),
        .PKT_W    (PKT_W),
        .RK_W     (RK_W)
    ) pages_i (
        .clk      (clk),
        .rst      (rst),
        .rel_a_en (rel_a),
        .rel_a_pkt(cmd_pkt),
        .rel_b_en (rel_b),
        .rel_b_pkt(tx_done_pkt),
        .claim_en (busy_q),
        .claim_pkt(cur_pkt_q),
        .freed_cnt(freed_cnt),
        .xl_pkt   (xl_pkt),
        .xl_rank  (xl_offset[BYTE_W-1:PAGE_SHIFT]),
        .xl_hit   (xl_hit),
        .xl_page  (xl_page)
    );

    pga_num_fifo #(.DEPTH(NUM_PKTS), .W(PKT_W)) txq_i (
        .clk(clk), .rst(rst),
        .push(host_go && cmd_e == CMD_ENQ_TX), .push_data(cmd_pkt),
        .pop(tx_pop), .head(tx_head), .empty(tx_empty)
    );

    pga_num_fifo #(.DEPTH(NUM_PKTS), .W(PKT_W)) doneq_i (
        .clk(clk), .rst(rst),
        .push(tx_done_valid && !auto_release), .push_data(tx_done_pkt),
        .pop(host_go && cmd_e == CMD_POP_DONE), .head(done_head), .empty(done_empty)
    );

    pga_num_fifo #(.DEPTH(NUM_PKTS), .W(PKT_W)) rxq_i (
        .clk(clk), .rst(rst),
        .push(rx_push), .push_data(cur_pkt_q),
        .pop(host_go && cmd_e == CMD_POP_RX), .head(rx_head), .empty(rx_empty)
    );

    assign busy       = busy_q;
    assign alloc_done = done_q;
    assign alloc_fail = fail_q;
    assign alloc_pkt  = cur_pkt_q;
    assign free_pages = free_q;
    assign rx_overrun = ovr_q;
    assign xl_addr    = {xl_page, xl_offset[PAGE_SHIFT-1:0]};
endmodule

// File: rtl/pga_chk.sv
module pga_chk #(
    parameter int NUM_PAGES = 24,
    parameter int CNT_W     = 5,
    parameter int ADDR_W    = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [2:0]        cmd_code,
    input logic              busy,
    input logic              alloc_done,
    input logic              alloc_fail,
    input logic [CNT_W-1:0]  free_pages,
    input logic              rx_alloc_req,
    input logic              rx_overrun,
    input logic              tx_done_valid,
    input logic              tx_empty,
    input logic              xl_hit,
    input logic [ADDR_W-1:0] xl_addr
);
    // R1
    free_bound_chk: assert property (@(posedge clk) disable iff (rst)
        free_pages <= CNT_W'(NUM_PAGES));

    // R2
    done_at_fall_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_done |-> (!busy && $past(busy)));

    // R3
    fail_keeps_pool_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_fail && !$past(tx_done_valid) && !$past(rx_alloc_req))
            |-> (free_pages == $past(free_pages) && !busy));

    // R4
    busy_blocks_enq_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid && cmd_code == 3'd6 && tx_empty) |=> tx_empty);

    // R8
    rx_busy_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && rx_alloc_req) |=> rx_overrun);

    // R10
    xl_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        xl_hit |-> (xl_addr[ADDR_W-1:8] < (ADDR_W-8)'(NUM_PAGES)));
endmodule

bind pga_top pga_chk #(
    .NUM_PAGES(NUM_PAGES),
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code),
    .busy         (busy),
    .alloc_done   (alloc_done),
    .alloc_fail   (alloc_fail),
    .free_pages   (free_pages),
    .rx_alloc_req (rx_alloc_req),
    .rx_overrun   (rx_overrun),
    .tx_done_valid(tx_done_valid),
    .tx_empty     (tx_empty),
    .xl_hit       (xl_hit),
    .xl_addr      (xl_addr)
);

// File: tb/pga_top_tb_top.sv
module pga_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = 3'd0;
    logic [12:0] cmd_bytes = '0;
    logic [3:0]  cmd_pkt = '0;
    logic        busy, alloc_done, alloc_fail;
    logic [3:0]  alloc_pkt;
    logic [4:0]  free_pages;
    logic        auto_release = 1'b0;
    logic        rx_alloc_req = 1'b0;
    logic [12:0] rx_alloc_bytes = '0;
    logic        rx_overrun;
    logic [3:0]  rx_head;
    logic        rx_empty;
    logic        tx_pop = 1'b0;
    logic [3:0]  tx_head;
    logic        tx_empty;
    logic        tx_done_valid = 1'b0;
    logic [3:0]  tx_done_pkt = '0;
    logic [3:0]  done_head;
    logic        done_empty;
    logic [3:0]  xl_pkt = '0;
    logic [12:0] xl_offset = '0;
    logic [12:0] xl_addr;
    logic        xl_hit;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pga_top dut_i (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bytes(cmd_bytes), .cmd_pkt(cmd_pkt),
        .busy(busy), .alloc_done(alloc_done), .alloc_fail(alloc_fail), .alloc_pkt(alloc_pkt),
        .free_pages(free_pages), .auto_release(auto_release),
        .rx_alloc_req(rx_alloc_req), .rx_alloc_bytes(rx_alloc_bytes), .rx_overrun(rx_overrun),
        .rx_head(rx_head), .rx_empty(rx_empty),
        .tx_pop(tx_pop), .tx_head(tx_head), .tx_empty(tx_empty),
        .tx_done_valid(tx_done_valid), .tx_done_pkt(tx_done_pkt),
        .done_head(done_head), .done_empty(done_empty),
        .xl_pkt(xl_pkt), .xl_offset(xl_offset), .xl_addr(xl_addr), .xl_hit(xl_hit)
    );

    typedef struct packed {
        logic [2:0]  code;
        logic [12:0] nbytes;
        logic [3:0]  pkt;
        logic [4:0]  exp_free;
        logic [1:0]  exp_kind;   // 0 none, 1 done, 2 fail
        logic [3:0]  exp_pkt;
        logic [4:0]  exp_cyc;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 13'd256,  4'd0, 5'd23, 2'd1, 4'd0, 5'd1},
        '{3'd1, 13'd600,  4'd0, 5'd20, 2'd1, 4'd1, 5'd3},
        '{3'd1, 13'd0,    4'd0, 5'd19, 2'd1, 4'd2, 5'd1},
        '{3'd1, 13'd5000, 4'd0, 5'd19, 2'd2, 4'd0, 5'd0},
        '{3'd2, 13'd0,    4'd1, 5'd22, 2'd0, 4'd0, 5'd0},
        '{3'd1, 13'd513,  4'd0, 5'd19, 2'd1, 4'd1, 5'd3},
        '{3'd2, 13'd0,    4'd5, 5'd19, 2'd0, 4'd0, 5'd0},
        '{3'd1, 13'd4864, 4'd0, 5'd0,  2'd1, 4'd3, 5'd19},
        '{3'd1, 13'd1,    4'd0, 5'd0,  2'd2, 4'd0, 5'd0},
        '{3'd2, 13'd0,    4'd3, 5'd19, 2'd0, 4'd0, 5'd0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] code, input logic [12:0] nb, input logic [3:0] pk);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = code;
        cmd_bytes = nb;
        cmd_pkt   = pk;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy && cyc < 100) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic xl(input logic [3:0] pk, input logic [12:0] off, input bit hit, input int addr, input string req);
        xl_pkt    = pk;
        xl_offset = off;
        #1;
        chk(xl_hit == hit, req, int'(xl_hit), int'(hit));
        if (hit) chk(xl_addr == 13'(addr), req, int'(xl_addr), addr);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R1: values during reset
        chk(free_pages == 5'd24, "R1 free in reset", free_pages, 24);
        rst = 1'b0;
        @(negedge clk);
        chk(free_pages == 5'd24, "R1 free", free_pages, 24);
        chk(!busy && !alloc_done && !alloc_fail && !rx_overrun, "R1 flags", busy, 0);
        chk(tx_empty && rx_empty && done_empty, "R1 queues", tx_empty & rx_empty & done_empty, 1);

        // R2 R3 R5: vector table
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].code, VECS[i].nbytes, VECS[i].pkt);
            if (VECS[i].exp_kind == 2'd2)
                chk(alloc_fail == 1'b1, "R3 fail pulse", alloc_fail, 1);
            wait_idle(cyc);
            if (VECS[i].exp_kind == 2'd1) begin
                chk(cyc == int'(VECS[i].exp_cyc), "R2 busy cycles", cyc, VECS[i].exp_cyc);
                chk(alloc_done == 1'b1, "R2 done pulse", alloc_done, 1);
                chk(alloc_pkt == VECS[i].exp_pkt, "R2 packet number", alloc_pkt, VECS[i].exp_pkt);
            end
            if (VECS[i].exp_kind == 2'd2)
                chk(cyc == 0, "R3 no busy", cyc, 0);
            chk(free_pages == VECS[i].exp_free, VECS[i].code == 3'd2 ? "R5 free after release" : "R2 free count",
                free_pages, VECS[i].exp_free);
        end

        // R10: pkt0 {0}, pkt1 {1,2,3}, pkt2 {4}
        xl(4'd1, 13'h105, 1'b1, 13'h205, "R10 second page");
        xl(4'd1, 13'h2FF, 1'b1, 13'h3FF, "R10 third page");
        xl(4'd1, 13'h300, 1'b0, 0, "R10 past end");
        xl(4'd5, 13'h000, 1'b0, 0, "R10 unused number");
        xl(4'd0, 13'h010, 1'b1, 13'h010, "R10 single page");
        xl(4'd2, 13'h000, 1'b1, 13'h400, "R10 pkt2");

        // R4: commands during a 4-page allocation are ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 3'd1; cmd_bytes = 13'd1024; cmd_pkt = 4'd0;
        @(negedge clk);
        cmd_code = 3'd6; cmd_pkt = 4'd0;
        @(negedge clk);
        cmd_code = 3'd2; cmd_pkt = 4'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_idle(cyc);
        chk(alloc_pkt == 4'd3, "R4 alloc number", alloc_pkt, 3);
        chk(free_pages == 5'd15, "R4 release ignored", free_pages, 15);
        chk(tx_empty == 1'b1, "R4 enqueue ignored", tx_empty, 1);
        xl(4'd0, 13'h000, 1'b1, 13'h000, "R4 pkt0 still owned");

        // R6: transmit queue order
        issue(3'd6, 13'd0, 4'd2);
        issue(3'd6, 13'd0, 4'd0);
        chk(!tx_empty && tx_head == 4'd2, "R6 head first", tx_head, 2);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
        chk(!tx_empty && tx_head == 4'd0, "R6 head second", tx_head, 0);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
        chk(tx_empty == 1'b1, "R6 drained", tx_empty, 1);

        // R7: completion without auto release
        tx_done_valid = 1'b1; tx_done_pkt = 4'd2;
        @(negedge clk);
        tx_done_valid = 1'b0;
        chk(!done_empty && done_head == 4'd2, "R7 completion queued", done_head, 2);
        chk(free_pages == 5'd15, "R7 pages kept", free_pages, 15);
        // R11: pops
        issue(3'd4, 13'd0, 4'd0);
        chk(done_empty == 1'b1, "R11 completion pop", done_empty, 1);
        issue(3'd4, 13'd0, 4'd0);
        chk(done_empty == 1'b1, "R11 empty pop", done_empty, 1);
        issue(3'd3, 13'd0, 4'd0);
        chk(rx_empty == 1'b1, "R11 empty rx pop", rx_empty, 1);

        // R7: auto release
        auto_release = 1'b1;
        tx_done_valid = 1'b1; tx_done_pkt = 4'd2;
        @(negedge clk);
        tx_done_valid = 1'b0;
        auto_release = 1'b0;
        chk(free_pages == 5'd16, "R7 auto freed", free_pages, 16);
        chk(done_empty == 1'b1, "R7 completion untouched", done_empty, 1);

        // R8: receive allocation
        rx_alloc_req = 1'b1; rx_alloc_bytes = 13'd300;
        @(negedge clk);
        rx_alloc_req = 1'b0;
        wait_idle(cyc);
        chk(cyc == 2, "R8 rx busy cycles", cyc, 2);
        chk(alloc_done == 1'b0, "R8 no host done", alloc_done, 0);
        chk(!rx_empty && rx_head == 4'd2, "R8 rx queued", rx_head, 2);
        chk(free_pages == 5'd14, "R8 rx free", free_pages, 14);

        // R8: receive request while busy
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 3'd1; cmd_bytes = 13'd256;
        @(negedge clk);
        cmd_valid = 1'b0;
        rx_alloc_req = 1'b1; rx_alloc_bytes = 13'd10;
        @(negedge clk);
        rx_alloc_req = 1'b0;
        chk(rx_overrun == 1'b1, "R8 overrun when busy", rx_overrun, 1);
        chk(alloc_done == 1'b1 && alloc_pkt == 4'd4, "R2 host pkt4", alloc_pkt, 4);
        chk(free_pages == 5'd13, "R8 free after overrun", free_pages, 13);

        // R9: same-cycle contention
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 3'd1; cmd_bytes = 13'd256;
        rx_alloc_req = 1'b1; rx_alloc_bytes = 13'd256;
        @(negedge clk);
        cmd_valid = 1'b0;
        rx_alloc_req = 1'b0;
        chk(alloc_fail == 1'b1, "R9 host loses", alloc_fail, 1);
        chk(busy == 1'b1, "R9 rx served", busy, 1);
        wait_idle(cyc);
        chk(free_pages == 5'd12, "R9 free", free_pages, 12);
        issue(3'd3, 13'd0, 4'd0);
        chk(!rx_empty && rx_head == 4'd5, "R11 rx pop to pkt5", rx_head, 5);

        // R8: receive request larger than pool
        rx_alloc_req = 1'b1; rx_alloc_bytes = 13'd5000;
        @(negedge clk);
        rx_alloc_req = 1'b0;
        chk(rx_overrun == 1'b1, "R8 overrun on size", rx_overrun, 1);
        chk(free_pages == 5'd12 && !busy, "R8 pool intact", free_pages, 12);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule